// File: doc/BRIEF.md
# Two-Channel Cycle-Stealing DMA Controller

This block moves data on behalf of a processor by taking the memory bus for one short burst per request. It has two independent channels. Each channel keeps a programmed source address, a programmed destination address and a reload count, plus a working address and a working count that it updates as it runs. Per-channel control bits choose byte or halfword units, which side (source, destination or neither) walks through memory, and whether the channel stops after a block or restarts automatically.

Software programs a channel through a small register port and sets its enable bit. Each pulse on that channel's request input then causes one transfer: a read from the source address followed by a write of the same data to the destination address, on a simple memory master port. The working count is decremented after every transfer. When it underflows the channel pulses its interrupt output and either stops (single mode) or reloads its count and keeps going (repeat mode). A single transfer engine is shared between the channels, and channel 0 wins when both are waiting.

Top module: `dma2_ctrl`

## Requirements
- R1: After reset every register reads 0, `mem_req` is 0 and `irq` is 0.
- R2: With a channel enabled, one request pulse gives exactly one read cycle (`mem_req`=1, `mem_we`=0) at the source address. Two cycles later comes one write cycle (`mem_req`=1, `mem_we`=1) at the destination address. The write carries the read data: all 16 bits for halfword units, or the low byte zero-extended for byte units. `mem_size` is 1 for halfword units and 0 for byte units.
- R3: When a write sets the enable bit, and it was clear before, the working pointer is loaded from the advancing side's programmed pointer and the working count is loaded from the reload register.
- R4: After each transfer the working pointer of an advancing side goes up by 1 (byte units) or 2 (halfword units), wrapping within 20 bits. A fixed side's address never changes.
- R5: The working count goes down by 1 per transfer. A transfer made while the count is 0 is an underflow, so a reload value N gives N+1 transfers. An underflow raises the channel's `irq` bit for exactly one clock.
- R6: In single mode an underflow clears the enable bit, and later requests cause no bus cycle.
- R7: In repeat mode an underflow reloads the working count from the reload register, and the enable bit stays 1.
- R8: If both channels request in the same cycle, channel 0's read is issued first, then channel 1's.
- R9: A request that arrives while a transfer is in progress is held and carried out afterwards, not dropped.
- R10: A request to a channel whose enable bit is 0 causes no bus cycle.
- R11: A write to the pointer register of the advancing side is always accepted. A write to the pointer register of a fixed side is ignored while the channel is enabled.
- R12: Reads have one cycle of latency. While a channel is enabled, reading the advancing side's pointer register returns the working pointer; otherwise it returns the programmed value. Register index is `reg_addr[2:0]`: 0 source pointer, 1 destination pointer, 2 reload count, 3 control, 4 working count. `reg_addr[3]` selects the channel. Control bits: 0 enable, 1 halfword unit, 2 source advances, 3 destination advances, 4 repeat mode.
- R13: A control write that sets both advance bits is stored with the destination advance bit cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Channel (bit 3) and register index (bits 2:0) |
| reg_wdata | input | 20 | Register write data |
| reg_rdata | output | 20 | Register read data, one cycle after `reg_addr` |
| dma_req | input | 2 | Per-channel transfer request, one cycle per event |
| mem_req | output | 1 | Memory cycle valid |
| mem_we | output | 1 | 1 for a write cycle, 0 for a read cycle |
| mem_size | output | 1 | 1 halfword, 0 byte |
| mem_addr | output | 20 | Memory address |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid the cycle after a read cycle |
| irq | output | 2 | Per-channel underflow pulse |

## Verification
Transfers are driven under each legal advance setting: source only, destination only, and neither. This shows whether the working pointer is applied to the correct side and whether a fixed address stays put. Byte and halfword runs differ in step size and in how data is masked. A destination walk across the top of the address space exposes any wrap fault. Single and repeat blocks with small reload counts put underflows close together, so the stop and reload paths and the interrupt pulse are exercised many times. Same-cycle requests and requests that land mid-transfer separate fixed priority and pending handling from request loss.

// File: rtl/dmac_pkg.sv
package dmac_pkg;

  typedef enum logic [1:0] {
    ENG_IDLE = 2'd0,
    ENG_RD   = 2'd1,
    ENG_CAP  = 2'd2,
    ENG_WR   = 2'd3
  } eng_state_t;

  typedef struct packed {
    logic rpt;
    logic dst_adv;
    logic src_adv;
    logic unit16;
    logic en;
  } chan_ctl_t;

  localparam logic [2:0] IDX_SRC = 3'd0;
  localparam logic [2:0] IDX_DST = 3'd1;
  localparam logic [2:0] IDX_RLD = 3'd2;
  localparam logic [2:0] IDX_CTL = 3'd3;
  localparam logic [2:0] IDX_CNT = 3'd4;

endpackage

// File: rtl/dmac_chan.sv
module dmac_chan
  import dmac_pkg::*;
#(
  parameter int AW = 20,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [2:0]    reg_idx,
  input  logic [AW-1:0] wr_data,
  output logic [AW-1:0] rd_data,
  input  logic          req,
  input  logic          grant,
  input  logic          done,
  output logic          pend_o,
  output logic [AW-1:0] src_addr_o,
  output logic [AW-1:0] dst_addr_o,
  output logic          unit16_o,
  output logic          irq_o
);

  chan_ctl_t     ctl, wr_ctl;
  logic [AW-1:0] src_reg, dst_reg, wptr, step;
  logic [CW-1:0] rld_reg, wcnt;
  logic          pend;
  logic          src_wr_ok, dst_wr_ok;

  always_comb begin
    wr_ctl = chan_ctl_t'(wr_data[4:0]);
    if (wr_ctl.src_adv) wr_ctl.dst_adv = 1'b0;
  end

  assign src_wr_ok = ctl.src_adv || !ctl.en;
  assign dst_wr_ok = ctl.dst_adv || !ctl.en;
  assign step      = ctl.unit16 ? AW'(2) : AW'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl     <= '0;
      src_reg <= '0;
      dst_reg <= '0;
      rld_reg <= '0;
      wptr    <= '0;
      wcnt    <= '0;
      pend    <= 1'b0;
      irq_o   <= 1'b0;
    end else begin
      irq_o <= 1'b0;
      pend  <= (pend && !grant) || (req && ctl.en);
      if (done) begin
        if (ctl.src_adv || ctl.dst_adv) wptr <= wptr + step;
        if (wcnt == '0) begin
          irq_o <= 1'b1;
          if (ctl.rpt) begin
            wcnt <= rld_reg;
          end else begin
            wcnt   <= '1;
            ctl.en <= 1'b0;
            pend   <= 1'b0;
          end
        end else begin
          wcnt <= wcnt - 1'b1;
        end
      end
      if (wr_en) begin
        case (reg_idx)
          IDX_SRC: if (src_wr_ok) src_reg <= wr_data;
          IDX_DST: if (dst_wr_ok) dst_reg <= wr_data;
          IDX_RLD: rld_reg <= wr_data[CW-1:0];
          IDX_CTL: begin
            ctl <= wr_ctl;
            if (wr_ctl.en && !ctl.en) begin
              wptr <= wr_ctl.src_adv ? src_reg : dst_reg;
              wcnt <= rld_reg;
            end
            if (!wr_ctl.en) pend <= 1'b0;
          end
          default: ;
        endcase
      end
    end
  end

  assign pend_o     = pend && ctl.en;
  assign src_addr_o = ctl.src_adv ? wptr : src_reg;
  assign dst_addr_o = ctl.dst_adv ? wptr : dst_reg;
  assign unit16_o   = ctl.unit16;

  always_comb begin
    case (reg_idx)
      IDX_SRC: rd_data = (ctl.en && ctl.src_adv) ? wptr : src_reg;
      IDX_DST: rd_data = (ctl.en && ctl.dst_adv) ? wptr : dst_reg;
      IDX_RLD: rd_data = AW'(rld_reg);
      IDX_CTL: rd_data = AW'(ctl);
      IDX_CNT: rd_data = AW'(wcnt);
      default: rd_data = '0;
    endcase
  end

endmodule

// File: rtl/dmac_prio_arb.sv
module dmac_prio_arb #(
  parameter int N   = 2,
  parameter int IW  = 1
) (
  input  logic [N-1:0]  req,
  output logic [N-1:0]  gnt,
  output logic [IW-1:0] idx,
  output logic          any
);

  always_comb begin
    gnt = '0;
    idx = '0;
    any = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (req[i] && !any) begin
        gnt[i] = 1'b1;
        idx    = IW'(i);
        any    = 1'b1;
      end
    end
  end

endmodule

// File: rtl/dmac_engine.sv
module dmac_engine
  import dmac_pkg::*;
#(
  parameter int NCH = 2,
  parameter int AW  = 20,
  parameter int DW  = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NCH-1:0]          pend,
  input  logic [NCH-1:0][AW-1:0]  src_addr,
  input  logic [NCH-1:0][AW-1:0]  dst_addr,
  input  logic [NCH-1:0]          unit16,
  output logic [NCH-1:0]          grant,
  output logic [NCH-1:0]          done,
  output logic                    mem_req,
  output logic                    mem_we,
  output logic                    mem_size,
  output logic [AW-1:0]           mem_addr,
  output logic [DW-1:0]           mem_wdata,
  input  logic [DW-1:0]           mem_rdata
);

  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1;

  eng_state_t     state;
  logic [CHW-1:0] cur, sel;
  logic [AW-1:0]  dst_lat;
  logic [NCH-1:0] arb_gnt;
  logic           arb_any;

  dmac_prio_arb #(.N(NCH), .IW(CHW)) u_arb (
    .req (pend),
    .gnt (arb_gnt),
    .idx (sel),
    .any (arb_any)
  );

  assign grant = (state == ENG_IDLE) ? arb_gnt : '0;

  always_comb begin
    done = '0;
    for (int i = 0; i < NCH; i++)
      done[i] = (state == ENG_WR) && (cur == CHW'(i));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ENG_IDLE;
      cur       <= '0;
      dst_lat   <= '0;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_size  <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      case (state)
        ENG_IDLE: if (arb_any) begin
          state    <= ENG_RD;
          cur      <= sel;
          mem_req  <= 1'b1;
          mem_we   <= 1'b0;
          mem_addr <= src_addr[sel];
          mem_size <= unit16[sel];
          dst_lat  <= dst_addr[sel];
        end
        ENG_RD: begin
          mem_req <= 1'b0;
          state   <= ENG_CAP;
        end
        ENG_CAP: begin
          mem_req   <= 1'b1;
          mem_we    <= 1'b1;
          mem_addr  <= dst_lat;
          mem_wdata <= mem_size ? mem_rdata : {{(DW-8){1'b0}}, mem_rdata[7:0]};
          state     <= ENG_WR;
        end
        default: begin
          mem_req <= 1'b0;
          mem_we  <= 1'b0;
          state   <= ENG_IDLE;
        end
      endcase
    end
  end

endmodule

// File: rtl/dma2_ctrl.sv
module dma2_ctrl #(
  parameter int AW = 20,
  parameter int CW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_wr,
  input  logic [3:0]    reg_addr,
  input  logic [AW-1:0] reg_wdata,
  output logic [AW-1:0] reg_rdata,
  input  logic [1:0]    dma_req,
  output logic          mem_req,
  output logic          mem_we,
  output logic          mem_size,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic [1:0]    irq
);

  localparam int NCH = 2;

  logic [NCH-1:0][AW-1:0] rd_data, src_addr, dst_addr;
  logic [NCH-1:0]         pend, grant, done, unit16;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    dmac_chan #(.AW(AW), .CW(CW)) u_ch (
      .clk        (clk),
      .rst        (rst),
      .wr_en      (reg_wr && (reg_addr[3] == 1'(g))),
      .reg_idx    (reg_addr[2:0]),
      .wr_data    (reg_wdata),
      .rd_data    (rd_data[g]),
      .req        (dma_req[g]),
      .grant      (grant[g]),
      .done       (done[g]),
      .pend_o     (pend[g]),
      .src_addr_o (src_addr[g]),
      .dst_addr_o (dst_addr[g]),
      .unit16_o   (unit16[g]),
      .irq_o      (irq[g])
    );
  end

  dmac_engine #(.NCH(NCH), .AW(AW), .DW(DW)) u_eng (
    .clk       (clk),
    .rst       (rst),
    .pend      (pend),
    .src_addr  (src_addr),
    .dst_addr  (dst_addr),
    .unit16    (unit16),
    .grant     (grant),
    .done      (done),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_size  (mem_size),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_data[reg_addr[3]];
  end

endmodule

// File: rtl/dma2_ctrl_chk.sv
module dma2_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       mem_req,
  input logic       mem_we,
  input logic       mem_size,
  input logic [1:0] irq
);

  AST_IRQ0_PULSE: assert property (@(posedge clk) disable iff (rst) irq[0] |=> !irq[0]); // R5
  AST_IRQ1_PULSE: assert property (@(posedge clk) disable iff (rst) irq[1] |=> !irq[1]); // R5
  AST_ONE_IRQ_AT_A_TIME: assert property (@(posedge clk) disable iff (rst) $countones(irq) <= 1); // R8
  AST_READ_THEN_WRITE: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_we) |=> (!mem_req ##1 (mem_req && mem_we))); // R2
  AST_WRITE_HAS_READ: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we) |-> $past(mem_req && !mem_we, 2)); // R2
  AST_SIZE_HELD: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we) |-> (mem_size == $past(mem_size, 2))); // R2
  AST_WRITE_ENDS: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we) |=> !mem_req); // R9

endmodule

bind dma2_ctrl dma2_ctrl_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .mem_req  (mem_req),
  .mem_we   (mem_we),
  .mem_size (mem_size),
  .irq      (irq)
);

// File: tb/sim_dma2_ctrl.sv
module sim_dma2_ctrl;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [19:0] reg_wdata = '0;
  logic [19:0] reg_rdata;
  logic [1:0]  dma_req = '0;
  logic        mem_req, mem_we, mem_size;
  logic [19:0] mem_addr;
  logic [15:0] mem_wdata;
  logic [15:0] mem_rdata = '0;
  logic [1:0]  irq;

  always #4 clk = ~clk;

  dma2_ctrl u0 (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dma_req(dma_req),
    .mem_req(mem_req), .mem_we(mem_we), .mem_size(mem_size),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .irq(irq)
  );

  int n_chk = 0, n_fail = 0, cyc = 0;

  function automatic logic [15:0] mdata(input logic [19:0] a);
    return a[15:0] ^ {a[19:16], 12'hA53};
  endfunction

  always @(posedge clk) if (mem_req && !mem_we) mem_rdata <= mdata(mem_addr);

  int          wr_n = 0, rd_n = 0;
  int          irq_n [2];
  logic [19:0] last_waddr, last_raddr;
  logic [15:0] last_wdata;
  logic        last_wsize;
  logic [19:0] rd_log [8];

  initial begin irq_n[0] = 0; irq_n[1] = 0; end

  always @(posedge clk) begin
    if (!rst) begin
      if (mem_req && mem_we) begin
        wr_n++; last_waddr = mem_addr; last_wdata = mem_wdata; last_wsize = mem_size;
      end
      if (mem_req && !mem_we) begin
        rd_log[rd_n % 8] = mem_addr; last_raddr = mem_addr; rd_n++;
      end
      if (irq[0]) irq_n[0]++;
      if (irq[1]) irq_n[1]++;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog act=%0d exp<150000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input int ch, input logic [2:0] idx, input logic [19:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = {ch[0], idx}; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input int ch, input logic [2:0] idx, output logic [19:0] d);
    @(negedge clk);
    reg_addr = {ch[0], idx};
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic pulse(input logic [1:0] m);
    @(negedge clk); dma_req = m;
    @(negedge clk); dma_req = '0;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // bench model of each channel
  logic [19:0] m_src [2], m_dst [2], m_ptr [2];
  logic [15:0] m_rld [2], m_cnt [2];
  logic        m_en [2], m_u16 [2], m_sa [2], m_da [2], m_rp [2];

  task automatic model_adv(input int ch, output bit uf);
    uf = 1'b0;
    if (m_sa[ch] || m_da[ch]) m_ptr[ch] = m_ptr[ch] + (m_u16[ch] ? 20'd2 : 20'd1);
    if (m_cnt[ch] == 16'd0) begin
      uf = 1'b1;
      if (m_rp[ch]) m_cnt[ch] = m_rld[ch];
      else begin m_cnt[ch] = 16'hFFFF; m_en[ch] = 1'b0; end
    end else m_cnt[ch] = m_cnt[ch] - 16'd1;
  endtask

  task automatic prog(input int ch, input logic [19:0] s, input logic [19:0] d,
                      input logic [15:0] r, input bit u, input bit sa, input bit da, input bit rp);
    wr_reg(ch, 3'd3, 20'd0);
    wr_reg(ch, 3'd0, s);
    wr_reg(ch, 3'd1, d);
    wr_reg(ch, 3'd2, {4'd0, r});
    wr_reg(ch, 3'd3, {15'd0, rp, da, sa, u, 1'b1});
    m_src[ch] = s; m_dst[ch] = d; m_rld[ch] = r; m_u16[ch] = u;
    m_sa[ch] = sa; m_da[ch] = da && !sa; m_rp[ch] = rp; m_en[ch] = 1'b1;
    m_ptr[ch] = sa ? s : d; m_cnt[ch] = r;
  endtask

  task automatic xfer(input int ch, input string tag);
    int w0, i0;
    logic [19:0] ra, wa;
    logic [15:0] dd;
    bit uf;
    w0 = wr_n; i0 = irq_n[ch];
    pulse(ch == 0 ? 2'b01 : 2'b10);
    settle(8);
    if (m_en[ch]) begin
      ra = m_sa[ch] ? m_ptr[ch] : m_src[ch];
      wa = m_da[ch] ? m_ptr[ch] : m_dst[ch];
      dd = mdata(ra);
      if (!m_u16[ch]) dd = {8'h00, dd[7:0]};
      chk({tag, " R2 one write"}, wr_n, w0 + 1);
      chk({tag, " R2 read addr"}, last_raddr, ra);
      chk({tag, " R4 write addr"}, last_waddr, wa);
      chk({tag, " R2 write data"}, last_wdata, dd);
      chk({tag, " R2 size"}, last_wsize, m_u16[ch]);
      model_adv(ch, uf);
      chk({tag, " R5 irq count"}, irq_n[ch], i0 + (uf ? 1 : 0));
    end else begin
      chk({tag, " R10 no write"}, wr_n, w0);
    end
  endtask

  logic [19:0] rv;
  int r0, w0;
  bit uf;

  initial begin
    void'($urandom(32'h5EED));
    for (int c = 0; c < 2; c++) begin
      m_en[c] = 0; m_src[c] = 0; m_dst[c] = 0; m_ptr[c] = 0;
      m_rld[c] = 0; m_cnt[c] = 0; m_u16[c] = 0; m_sa[c] = 0; m_da[c] = 0; m_rp[c] = 0;
    end
    settle(4);
    rst = 1'b0;

    // R1 reset state
    rd_reg(0, 3'd3, rv); chk("R1 ctl ch0", rv, 0);
    rd_reg(1, 3'd0, rv); chk("R1 src ch1", rv, 0);
    rd_reg(1, 3'd4, rv); chk("R1 cnt ch1", rv, 0);
    chk("R1 mem_req", mem_req, 0);
    chk("R1 irq", irq, 0);

    // single mode, halfword, source advances
    prog(0, 20'h12345, 20'h00F00, 16'd2, 1, 1, 0, 0);
    rd_reg(0, 3'd4, rv); chk("R3 count loaded", rv, 2);
    xfer(0, "R3");
    rd_reg(0, 3'd0, rv); chk("R12 live pointer", rv, 20'h12347);
    wr_reg(0, 3'd1, 20'h00001);
    rd_reg(0, 3'd1, rv); chk("R11 fixed side locked", rv, 20'h00F00);
    wr_reg(0, 3'd0, 20'h00777); m_src[0] = 20'h00777;
    rd_reg(0, 3'd4, rv); chk("R5 count down", rv, 1);
    xfer(0, "R5");
    xfer(0, "R6");
    rd_reg(0, 3'd3, rv); chk("R6 enable cleared", rv[0], 0);
    xfer(0, "R6");
    rd_reg(0, 3'd0, rv); chk("R11 advancing write kept", rv, 20'h00777);

    // byte units, destination advances across the top, repeat
    prog(1, 20'h00010, 20'hFFFFF, 16'd1, 0, 0, 1, 1);
    xfer(1, "R2");
    xfer(1, "R4");
    chk("R4 wrap", last_waddr, 20'h00000);
    rd_reg(1, 3'd3, rv); chk("R7 still enabled", rv[0], 1);
    rd_reg(1, 3'd4, rv); chk("R7 reloaded", rv, 1);
    rd_reg(1, 3'd0, rv); chk("R4 fixed src", rv, 20'h00010);

    // R8 priority
    prog(0, 20'h20000, 20'h00300, 16'd5, 1, 1, 0, 0);
    r0 = rd_n;
    pulse(2'b11);
    settle(16);
    chk("R8 two reads", rd_n, r0 + 2);
    chk("R8 ch0 first", rd_log[r0 % 8], 20'h20000);
    chk("R8 ch1 second", rd_log[(r0 + 1) % 8], 20'h00010);
    model_adv(0, uf);
    model_adv(1, uf);

    // R9 request while busy
    w0 = wr_n;
    @(negedge clk); dma_req = 2'b01;
    @(negedge clk); dma_req = 2'b00;
    @(negedge clk);
    @(negedge clk); dma_req = 2'b01;
    @(negedge clk); dma_req = 2'b00;
    settle(16);
    chk("R9 both served", wr_n, w0 + 2);
    model_adv(0, uf);
    model_adv(0, uf);
    xfer(0, "R9");

    // R13 both-advance setting
    wr_reg(1, 3'd3, 20'd0);
    wr_reg(1, 3'd3, 20'b01101);
    rd_reg(1, 3'd3, rv); chk("R13 dst adv cleared", rv, 20'b00101);
    m_en[1] = 1; m_sa[1] = 1; m_da[1] = 0; m_u16[1] = 0; m_rp[1] = 0;
    m_ptr[1] = m_src[1]; m_cnt[1] = m_rld[1];
    xfer(1, "R13");

    // R10 disabled channel
    wr_reg(1, 3'd3, 20'd0); m_en[1] = 0;
    xfer(1, "R10");

    // random blocks
    for (int k = 0; k < 40; k++) begin
      int ch, mode, nreq;
      ch   = $urandom % 2;
      mode = $urandom % 3;
      prog(ch, 20'($urandom), 20'($urandom), 16'($urandom % 4), bit'($urandom % 2),
           mode == 1, mode == 2, bit'($urandom % 2));
      nreq = 1 + $urandom % 6;
      for (int j = 0; j < nreq; j++) xfer(ch, "RND");
      rd_reg(ch, 3'd3, rv); chk("R6 R7 enable state", rv[0], m_en[ch]);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule